// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the programming front end of an eight-input priority interrupt controller. It receives byte writes and byte reads on a one-bit address. It walks an initialization word sequence and decodes the operation commands that follow. The commands cover end-of-interrupt, priority rotation, read selection, polling and special masking. It holds the request, in-service and mask registers and the rotating priority base. It decides whether to raise the interrupt output. On an acknowledge strobe it drives the vector, which is the programmed base with the winning input number in the low three bits.

A host first writes an initialization word to address 0, and the words that follow go to address 1. Later writes to address 1 load the mask. Later writes to address 0 are commands: bit 4 clear and bit 3 set selects the read/poll/special-mask group, and bits 4 and 3 both clear selects the end-of-interrupt/rotation group. Reads are combinational and valid while the read strobe is high. The state effects of a read, such as the clearing done by a poll, take place at the clock edge that ends the strobe. Cascading of several controllers and bus timing are not handled here.

Top module: `irq_cmd_decoder`

## Requirements
- R1: After reset the request, in-service and mask registers are zero, read-select is 0 (so a read at address 0 gives the request register), the priority base is 0 and the interrupt output is low.
- R2: A rising edge on request input k sets request bit k at the next clock edge; a line that stays high does not set the bit again once it has been cleared.
- R3: A write to address 0 with bit 4 set starts initialization. Bit 0 of that write records whether a fourth word will follow. The write clears the mask, the priority base, special mask, read-select and the stored input levels. If no fourth word is expected, it also clears special-nesting and auto-EOI.
- R4: After the first word, the next write to address 1 stores the vector base as data AND 0xF8. The one after that is accepted with its content ignored. If a fourth word is expected, the next write sets special-nesting from bit 4 and auto-EOI from bit 1. Only after that sequence do address-1 writes load the mask.
- R5: In normal state a write to address 1 loads the mask, and a read of address 1 returns it.
- R6: The interrupt output is high when the best unmasked request outranks the best in-service input. The rank of input k is (k - base) mod 8, and the smaller rank wins.
- R7: An acknowledge while the output is high returns the vector base OR the winning input. It sets that input's in-service bit and clears its request bit. With auto-EOI on, the in-service bit is not set, and if rotate-on-auto-EOI is also on the base becomes winner+1. An acknowledge with nothing winning returns base OR 7 and changes no state.
- R8: A write to address 0 with bit 4 clear and bit 3 set is a read/poll/special-mask command. Bit 2 arms poll. Bit 1 allows read-select to load from bit 0. Bit 6 allows special mask to load from bit 5.
- R9: A read of address 0 without poll returns the in-service register when read-select is 1, else the request register.
- R10: A read while poll is armed returns the winning input number and clears its request and in-service bits, or returns 7 if none wins. Any read disarms poll.
- R11: With bits 4 and 3 clear, bits 7:5 select the command. Code 1 clears the best-ranked in-service bit. Code 5 does the same and also sets the base to that input+1. Code 3 clears in-service bit data[2:0]. Code 7 clears that bit and sets the base to data[2:0]+1. Code 6 sets the base to data[2:0]+1. Codes 0 and 4 set rotate-on-auto-EOI to bit 7. Code 2 changes nothing.
- R12: With special mask on, masked in-service bits do not block lower-ranked requests.
- R13: With special-nesting on, in-service bit 2 does not block requests, so input 2 can interrupt itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| rd_i | input | 1 | Read strobe, one cycle per byte |
| addr_i | input | 1 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid while rd_i is high |
| irq_i | input | 8 | Edge-sensitive request inputs |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| vector_o | output | 8 | Vector, valid while ack_i is high |
| int_o | output | 1 | Interrupt request to the host |

## Verification
The hardest states to reach combine a rotated priority base with in-service bits that are still set. Reaching one takes an acknowledge, then a rotating command, then fresh requests, all in order. The bench gets there by chaining acknowledges with rotating EOI, specific-rotate and set-base commands. It then reads the winner back through poll reads, because each one has its own expected order. Special mask and special-nesting are reached the same way: an in-service bit is first pinned by an acknowledge, and the bench then shows that the output rises only when the mode is on.

// File: rtl/irq_cmd_pkg.sv
package irq_cmd_pkg;
  typedef enum logic [1:0] {
    INIT_IDLE = 2'd0,
    INIT_BASE = 2'd1,
    INIT_CASC = 2'd2,
    INIT_MODE = 2'd3
  } init_st_e;

  localparam logic [2:0] OP_ROT_OFF = 3'd0;
  localparam logic [2:0] OP_NS_EOI  = 3'd1;
  localparam logic [2:0] OP_NOP     = 3'd2;
  localparam logic [2:0] OP_SP_EOI  = 3'd3;
  localparam logic [2:0] OP_ROT_ON  = 3'd4;
  localparam logic [2:0] OP_RNS_EOI = 3'd5;
  localparam logic [2:0] OP_SET_PRI = 3'd6;
  localparam logic [2:0] OP_RSP_EOI = 3'd7;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  input  logic [IW-1:0] base_i,
  output logic          hit_o,
  output logic [IW:0]   rank_o,
  output logic [IW-1:0] idx_o
);
  localparam int DW2 = 2 * N;

  logic [DW2-1:0] dbl;
  logic [N-1:0]   rot;

  assign dbl = {vec_i, vec_i} >> base_i;
  assign rot = dbl[N-1:0];

  always_comb begin
    rank_o = IW'(0) + (IW+1)'(N);
    for (int i = N - 1; i >= 0; i--) begin
      if (rot[i]) rank_o = (IW+1)'(i);
    end
  end

  assign hit_o = |vec_i;
  assign idx_o = IW'(rank_o[IW-1:0] + base_i);
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_cmd_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [N-1:0]  imr_o,
  output logic [DW-1:0] vbase_o,
  output logic          sfnm_o,
  output logic          aeoi_o,
  output logic          rot_aeoi_o,
  output logic          smm_o,
  output logic          rsel_o,
  output logic          poll_o,
  output logic          init_o
);
  localparam int IW = $clog2(N);
  localparam logic [DW-1:0] VB_MASK = ~DW'((1 << IW) - 1);

  init_st_e st_q;
  logic     init4_q;
  logic     w0, w1, icw1, ocw3, ocw2;
  logic [2:0] op;

  assign w0   = wr_i && !addr_i;
  assign w1   = wr_i && addr_i;
  assign icw1 = w0 && wdata_i[4];
  assign ocw3 = w0 && !wdata_i[4] && wdata_i[3];
  assign ocw2 = w0 && !wdata_i[4] && !wdata_i[3];
  assign op   = wdata_i[7:5];
  assign init_o = icw1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= INIT_IDLE;
      init4_q    <= 1'b0;
      imr_o      <= '0;
      vbase_o    <= '0;
      sfnm_o     <= 1'b0;
      aeoi_o     <= 1'b0;
      rot_aeoi_o <= 1'b0;
      smm_o      <= 1'b0;
      rsel_o     <= 1'b0;
      poll_o     <= 1'b0;
    end else begin
      if (rd_i && poll_o) poll_o <= 1'b0;
      if (icw1) begin
        init4_q <= wdata_i[0];
        imr_o   <= '0;
        smm_o   <= 1'b0;
        rsel_o  <= 1'b0;
        if (!wdata_i[0]) begin
          sfnm_o <= 1'b0;
          aeoi_o <= 1'b0;
        end
        st_q <= INIT_BASE;
      end else if (ocw3) begin
        if (wdata_i[2]) poll_o <= 1'b1;
        if (wdata_i[1]) rsel_o <= wdata_i[0];
        if (wdata_i[6]) smm_o  <= wdata_i[5];
      end else if (ocw2) begin
        if (op == OP_ROT_OFF || op == OP_ROT_ON) rot_aeoi_o <= op[2];
      end
      if (w1) begin
        unique case (st_q)
          INIT_IDLE: imr_o <= wdata_i[N-1:0];
          INIT_BASE: begin
            vbase_o <= wdata_i & VB_MASK;
            st_q    <= INIT_CASC;
          end
          INIT_CASC: st_q <= init4_q ? INIT_MODE : INIT_IDLE;
          INIT_MODE: begin
            sfnm_o <= wdata_i[4];
            aeoi_o <= wdata_i[1];
            st_q   <= INIT_IDLE;
          end
          default: st_q <= INIT_IDLE;
        endcase
      end
    end
  end

  // R3
  icw1_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    icw1 |=> (imr_o == '0) && (st_q == INIT_BASE) && !rsel_o && !smm_o);

  // R4
  base_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w1 && !icw1 && st_q == INIT_BASE) |=> (vbase_o == ($past(wdata_i) & VB_MASK)));

  // R10
  poll_disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && poll_o && !wr_i) |=> !poll_o);
endmodule

// File: rtl/irq_req_regs.sv
module irq_req_regs #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  irq_i,
  input  logic          lvl_clr_i,
  input  logic [N-1:0]  irr_clr_i,
  input  logic [N-1:0]  isr_set_i,
  input  logic [N-1:0]  isr_clr_i,
  input  logic          base_we_i,
  input  logic [IW-1:0] base_d_i,
  output logic [N-1:0]  irr_o,
  output logic [N-1:0]  isr_o,
  output logic [IW-1:0] base_o
);
  logic [N-1:0] last_q;
  logic [N-1:0] edge_hit;

  assign edge_hit = irq_i & ~last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      irr_o  <= '0;
      isr_o  <= '0;
      base_o <= '0;
    end else begin
      last_q <= lvl_clr_i ? '0 : irq_i;
      irr_o  <= (irr_o & ~irr_clr_i) | edge_hit;
      isr_o  <= (isr_o & ~isr_clr_i) | isr_set_i;
      if (base_we_i) base_o <= base_d_i;
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_chk
    // R2
    edge_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_i[k] && !last_q[k]) |=> irr_o[k]);
    // R11
    isr_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (isr_clr_i[k] && !isr_set_i[k]) |=> !isr_o[k]);
  end
endmodule

// File: rtl/irq_cmd_decoder.sv
module irq_cmd_decoder
  import irq_cmd_pkg::*;
#(
  parameter int N  = 8,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [N-1:0]  irq_i,
  input  logic          ack_i,
  output logic [DW-1:0] vector_o,
  output logic          int_o
);
  localparam int IW      = $clog2(N);
  localparam int CAS_BIT = 2;
  localparam logic [IW-1:0] SPUR = IW'(N - 1);

  logic [N-1:0]  imr, irr, isr;
  logic [DW-1:0] vbase;
  logic          sfnm, aeoi, rot_aeoi, smm, rsel, poll, init_go;
  logic [IW-1:0] base;

  logic          p_hit, c_hit, e_hit;
  logic [IW:0]   p_rank, c_rank, e_rank;
  logic [IW-1:0] p_idx, c_idx, e_idx;
  logic [N-1:0]  pend_vec, cur_vec;
  logic          win, take, pread;

  logic          ocw2;
  logic [2:0]    op;
  logic [IW-1:0] arg;
  logic [N-1:0]  irr_clr, isr_set, isr_clr;
  logic          base_we;
  logic [IW-1:0] base_d;

  irq_cfg_regs #(.N(N), .DW(DW)) u_cfg (
    .clk_i, .rst_ni, .wr_i, .rd_i, .addr_i, .wdata_i,
    .imr_o(imr), .vbase_o(vbase), .sfnm_o(sfnm), .aeoi_o(aeoi),
    .rot_aeoi_o(rot_aeoi), .smm_o(smm), .rsel_o(rsel), .poll_o(poll),
    .init_o(init_go)
  );

  assign pend_vec = irr & ~imr;
  always_comb begin
    cur_vec = isr;
    if (sfnm) cur_vec[CAS_BIT] = 1'b0;
    if (smm)  cur_vec = cur_vec & ~imr;
  end

  irq_prio_pick #(.N(N), .IW(IW)) u_pend (
    .vec_i(pend_vec), .base_i(base), .hit_o(p_hit), .rank_o(p_rank), .idx_o(p_idx));
  irq_prio_pick #(.N(N), .IW(IW)) u_cur (
    .vec_i(cur_vec), .base_i(base), .hit_o(c_hit), .rank_o(c_rank), .idx_o(c_idx));
  irq_prio_pick #(.N(N), .IW(IW)) u_eoi (
    .vec_i(isr), .base_i(base), .hit_o(e_hit), .rank_o(e_rank), .idx_o(e_idx));

  assign win   = p_hit && (p_rank < c_rank);
  assign take  = ack_i && win;
  assign pread = rd_i && poll && win;

  assign ocw2 = wr_i && !addr_i && !wdata_i[4] && !wdata_i[3];
  assign op   = wdata_i[7:5];
  assign arg  = wdata_i[IW-1:0];

  always_comb begin
    irr_clr = '0;
    isr_set = '0;
    isr_clr = '0;
    base_we = 1'b0;
    base_d  = base;
    if (take) begin
      irr_clr[p_idx] = 1'b1;
      if (!aeoi) isr_set[p_idx] = 1'b1;
      else if (rot_aeoi) begin
        base_we = 1'b1;
        base_d  = IW'(p_idx + 1'b1);
      end
    end
    if (pread) begin
      irr_clr[p_idx] = 1'b1;
      isr_clr[p_idx] = 1'b1;
    end
    if (ocw2) begin
      unique case (op)
        OP_NS_EOI:  if (e_hit) isr_clr[e_idx] = 1'b1;
        OP_RNS_EOI: if (e_hit) begin
          isr_clr[e_idx] = 1'b1;
          base_we = 1'b1;
          base_d  = IW'(e_idx + 1'b1);
        end
        OP_SP_EOI:  isr_clr[arg] = 1'b1;
        OP_RSP_EOI: begin
          isr_clr[arg] = 1'b1;
          base_we = 1'b1;
          base_d  = IW'(arg + 1'b1);
        end
        OP_SET_PRI: begin
          base_we = 1'b1;
          base_d  = IW'(arg + 1'b1);
        end
        default: ;
      endcase
    end
    if (init_go) begin
      base_we = 1'b1;
      base_d  = '0;
    end
  end

  irq_req_regs #(.N(N), .IW(IW)) u_req (
    .clk_i, .rst_ni, .irq_i, .lvl_clr_i(init_go),
    .irr_clr_i(irr_clr), .isr_set_i(isr_set), .isr_clr_i(isr_clr),
    .base_we_i(base_we), .base_d_i(base_d),
    .irr_o(irr), .isr_o(isr), .base_o(base)
  );

  always_comb begin
    if (poll)        rdata_o = DW'(win ? p_idx : SPUR);
    else if (addr_i) rdata_o = DW'(imr);
    else if (rsel)   rdata_o = DW'(isr);
    else             rdata_o = DW'(irr);
  end

  assign vector_o = vbase | DW'(win ? p_idx : SPUR);
  assign int_o    = win;

  // R6
  int_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> |(irr & ~imr));

  // R7
  ack_isr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && int_o && !aeoi && !wr_i && !rd_i) |=> isr[$past(p_idx)] && !irr[$past(p_idx)]);

  // R7
  ack_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !int_o && !wr_i && !rd_i) |=> $stable(isr));

  // R1
  reset_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (isr == '0 && irr == '0) |-> !int_o);
endmodule

// File: tb/irq_cmd_decoder_test.sv
module irq_cmd_decoder_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0, rd = 1'b0, addr = 1'b0, ack = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, vector;
  logic [7:0] irq = '0;
  logic       intr;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_cmd_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_i(irq), .ack_i(ack),
    .vector_o(vector), .int_o(intr)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_b(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_b(input logic a, output logic [7:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a;
    #(CLK_PERIOD / 4);
    d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic ack_b(output logic [7:0] v);
    @(negedge clk);
    ack = 1'b1;
    #(CLK_PERIOD / 4);
    v = vector;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk);
    irq = irq | m;
    @(negedge clk);
    irq = irq & ~m;
  endtask

  task automatic expect_isr(input string req, input int exp);
    logic [7:0] d;
    wr_b(1'b0, 8'h0B);
    rd_b(1'b0, d);
    chk(req, d, exp);
    wr_b(1'b0, 8'h0A);
  endtask

  task automatic expect_poll(input string req, input int exp);
    logic [7:0] d;
    wr_b(1'b0, 8'h0C);
    rd_b(1'b0, d);
    chk(req, d, exp);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd_b(1'b0, d); chk("R1 irr", d, 0);
    rd_b(1'b1, d); chk("R1 imr", d, 0);
    chk("R1 int", intr, 0);
    expect_isr("R1 isr", 0);
  endtask

  task automatic t_init();
    logic [7:0] d;
    wr_b(1'b0, 8'h11);
    wr_b(1'b1, 8'h47);
    wr_b(1'b1, 8'h00);
    wr_b(1'b1, 8'h00);
    wr_b(1'b1, 8'hFF);
    rd_b(1'b1, d); chk("R5 imr readback", d, 8'hFF);
    wr_b(1'b1, 8'h00);
    rd_b(1'b1, d); chk("R5 imr clear", d, 0);
  endtask

  task automatic t_edge_ack();
    logic [7:0] d;
    @(negedge clk); irq[3] = 1'b1;
    rd_b(1'b0, d); chk("R2 edge sets irr", d, 8'h08);
    chk("R6 int raised", intr, 1);
    ack_b(d); chk("R7 vector", d, 8'h43);
    rd_b(1'b0, d); chk("R2 held high no reset", d, 0);
    wr_b(1'b0, 8'h0B);
    rd_b(1'b0, d); chk("R9 isr read", d, 8'h08);
    wr_b(1'b0, 8'h0A);
    rd_b(1'b0, d); chk("R9 irr read", d, 0);
    @(negedge clk); irq[3] = 1'b0;
  endtask

  task automatic t_nesting();
    logic [7:0] d;
    pulse(8'h22);
    chk("R6 higher preempts", intr, 1);
    ack_b(d); chk("R7 vector nested", d, 8'h41);
    chk("R6 lower blocked", intr, 0);
    wr_b(1'b0, 8'h20);
    expect_isr("R11 nonspecific eoi", 8'h08);
    chk("R6 still blocked", intr, 0);
    wr_b(1'b0, 8'h63);
    expect_isr("R11 specific eoi", 0);
    chk("R6 unblocked", intr, 1);
    ack_b(d); chk("R7 vector 5", d, 8'h45);
    wr_b(1'b0, 8'h20);
    expect_isr("R11 eoi cleanup", 0);
  endtask

  task automatic t_spurious();
    logic [7:0] d;
    ack_b(d); chk("R7 spurious vector", d, 8'h47);
    expect_isr("R7 spurious no isr", 0);
  endtask

  task automatic t_poll_rotate();
    logic [7:0] d;
    wr_b(1'b0, 8'hC2);
    pulse(8'h12);
    expect_poll("R11 set base then R10 poll", 4);
    rd_b(1'b0, d); chk("R10 poll disarmed", d, 8'h02);
    expect_poll("R10 poll second", 1);
    expect_poll("R10 poll none", 7);
  endtask

  task automatic t_rot_eoi();
    logic [7:0] d;
    pulse(8'h20);
    ack_b(d); chk("R7 vector 5 base3", d, 8'h45);
    wr_b(1'b0, 8'hA0);
    expect_isr("R11 rotating eoi clears", 0);
    pulse(8'h41);
    expect_poll("R11 rotating eoi base", 6);
    expect_poll("R11 rotating eoi next", 0);
  endtask

  task automatic t_rot_specific();
    logic [7:0] d;
    pulse(8'h02);
    ack_b(d); chk("R7 vector 1", d, 8'h41);
    wr_b(1'b0, 8'hE1);
    expect_isr("R11 rotate specific clears", 0);
    pulse(8'h06);
    expect_poll("R11 rotate specific base", 2);
    expect_poll("R11 rotate specific next", 1);
  endtask

  task automatic t_nop();
    logic [7:0] d;
    pulse(8'h10);
    ack_b(d); chk("R7 vector 4", d, 8'h44);
    wr_b(1'b0, 8'h40);
    expect_isr("R11 code 2 no effect", 8'h10);
    pulse(8'h0A);
    expect_poll("R11 base kept after nop", 3);
    expect_poll("R10 blocked returns 7", 7);
    wr_b(1'b0, 8'h20);
    expect_poll("R11 eoi then poll", 1);
  endtask

  task automatic t_special_mask();
    logic [7:0] d;
    pulse(8'h08);
    ack_b(d); chk("R7 vector 3", d, 8'h43);
    pulse(8'h40);
    chk("R12 blocked by isr", intr, 0);
    wr_b(1'b1, 8'h08);
    chk("R12 mask alone no effect", intr, 0);
    wr_b(1'b0, 8'h68);
    chk("R12 special mask on", intr, 1);
    wr_b(1'b0, 8'h48);
    chk("R8 special mask off", intr, 0);
    wr_b(1'b1, 8'h00);
    wr_b(1'b0, 8'h63);
    chk("R11 specific unblocks", intr, 1);
    expect_poll("R10 poll after smm", 6);
  endtask

  task automatic t_auto_eoi();
    logic [7:0] d;
    wr_b(1'b1, 8'h55);
    wr_b(1'b0, 8'h11);
    rd_b(1'b1, d); chk("R3 init clears mask", d, 0);
    wr_b(1'b1, 8'h88);
    wr_b(1'b1, 8'h55);
    rd_b(1'b1, d); chk("R4 third word ignored", d, 0);
    wr_b(1'b1, 8'h12);
    wr_b(1'b1, 8'h00);
    wr_b(1'b0, 8'h80);
    pulse(8'h04);
    ack_b(d); chk("R4 new vector base", d, 8'h8A);
    expect_isr("R7 auto eoi no isr", 0);
    pulse(8'h0A);
    expect_poll("R7 rotate on auto eoi", 3);
    expect_poll("R7 rotate on auto eoi next", 1);
    wr_b(1'b0, 8'h00);
  endtask

  task automatic t_nested_special();
    logic [7:0] d;
    wr_b(1'b0, 8'h11);
    wr_b(1'b1, 8'h88);
    wr_b(1'b1, 8'h00);
    wr_b(1'b1, 8'h10);
    pulse(8'h04);
    ack_b(d); chk("R7 vector 2", d, 8'h8A);
    pulse(8'h04);
    chk("R13 self nesting", intr, 1);
    wr_b(1'b0, 8'h10);
    wr_b(1'b1, 8'h88);
    wr_b(1'b1, 8'h00);
    chk("R3 no fourth word clears nesting", intr, 0);
    wr_b(1'b1, 8'h04);
    rd_b(1'b1, d); chk("R4 normal after three words", d, 8'h04);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_init();
    t_edge_ack();
    t_nesting();
    t_spurious();
    t_poll_rotate();
    t_rot_eoi();
    t_rot_specific();
    t_nop();
    t_special_mask();
    t_auto_eoi();
    t_nested_special();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule